// File: doc/BRIEF.md
# Dual-Clock Reset Sequencer

This block qualifies one active-low reset for a design that spans two unrelated clocks. The raw reset is brought into each clock domain through a short synchroniser. A per-domain counter then measures how many clock edges that domain has seen while its synchronised reset is low. When the synchronised reset releases, the domain declares itself ready only if the counter reached the required minimum. Otherwise it raises an incomplete-reset indication.

While reset is asserted, and for as long as the two domains have not both qualified, the status flags seen by the surrounding buffer logic are forced to a fixed start-up pattern. After both domains qualify, the flags computed elsewhere pass straight through. The rising edge of the raw reset also captures a 2-bit threshold-offset code. Downstream almost-full and almost-empty comparators read this code, and it stays constant until the next reset release.

Top module: `dual_clk_rst_seq`

## Requirements
- R1: In each domain the raw reset `rst_n` passes through a two-flop synchroniser. A low `rst_n` clears both flops at once. Release reaches the synchronised reset only on the second rising edge of that domain's clock after `rst_n` rises.
- R2: Each domain has its own edge counter. It counts every rising edge at which the synchronised reset is low, saturates at EDGE_MIN (default 4), and is cleared at every edge at which the synchronised reset is high. Because of R1, the two edges needed to release the synchroniser are included in the count.
- R3: A domain's done output (`done_a`, `done_b`) rises at the edge where its synchronised reset releases, provided the count including that edge equals EDGE_MIN. It is cleared immediately when `rst_n` goes low and otherwise keeps its value.
- R4: `rst_err` goes high when either domain releases with a count below EDGE_MIN. A domain never shows done and incomplete together. `rst_err` is cleared immediately by the next low `rst_n`.
- R5: `flags_o` carries the start-up pattern while `rst_n` is low, and also while `done_a` and `done_b` are not both high. The bits are: bit 5 almost-full = 1, bit 4 mailbox-2 full = 1, bit 3 mailbox-1 full = 1, bit 2 full = 0, bit 1 almost-empty = 0, bit 0 empty = 0 (6'b111000).
- R6: Once `done_a` and `done_b` are both high and `rst_n` is high, `flags_o` equals `live_flags` with no clock delay.
- R7: `ofs_code` captures `ofs_sel` on the rising edge of `rst_n` and holds that value through any later change of `ofs_sel`, until the next rising edge of `rst_n`.
- R8: Each domain qualifies on its own edge count only. A short domain does not prevent the other domain's done from rising.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Clock of domain A |
| clk_b | input | 1 | Clock of domain B, unrelated to clk_a |
| rst_n | input | 1 | Raw active-low reset, asynchronous to both clocks |
| ofs_sel | input | 2 | Threshold-offset select, captured on reset release |
| live_flags | input | 6 | Flags from the buffer logic, in the R5 bit order |
| done_a | output | 1 | Domain A reset qualified (clk_a domain) |
| done_b | output | 1 | Domain B reset qualified (clk_b domain) |
| rst_err | output | 1 | Reset released before a domain saw EDGE_MIN edges |
| flags_o | output | 6 | Start-up pattern or live flags, per R5/R6 |
| ofs_code | output | 2 | Latched threshold-offset code |

## Verification
The reset clears the done and incomplete outputs asynchronously, so the bench checks them one time unit after `rst_n` falls. A domain's done or incomplete result is due on the second rising edge of that domain's own clock after `rst_n` rises. The bench therefore issues one edge and checks that nothing has changed yet, then issues the second edge and checks the result. During those checks the other clock is held still. `flags_o` follows the done outputs and `live_flags` combinationally, so it is checked in the same quiet interval. `ofs_code` is checked after `ofs_sel` has already been moved to a different value.

// File: rtl/dcrs_pkg.sv
package dcrs_pkg;

  localparam int NUM_FLAGS = 6;
  localparam int NUM_DOM   = 2;

  typedef enum int {
    FLG_EMPTY  = 0,
    FLG_AEMPTY = 1,
    FLG_FULL   = 2,
    FLG_MBX1   = 3,
    FLG_MBX2   = 4,
    FLG_AFULL  = 5
  } flag_idx_e;

  // Start-up flag pattern: "space" flags high, "data present" flags low.
  function automatic logic [NUM_FLAGS-1:0] init_flags();
    logic [NUM_FLAGS-1:0] f;
    f = '0;
    f[FLG_AFULL] = 1'b1;
    f[FLG_MBX1]  = 1'b1;
    f[FLG_MBX2]  = 1'b1;
    return f;
  endfunction

  // Saturating increment used by the per-domain edge counter.
  function automatic int unsigned sat_inc(int unsigned v, int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

endpackage

// File: rtl/dcrs_rst_sync.sv
module dcrs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic pre_n,
  output logic sync_n
);
  logic [STAGES-1:0] sh_q;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign pre_n  = sh_q[STAGES-2];
  assign sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/dcrs_edge_qual.sv
module dcrs_edge_qual #(
  parameter int EDGE_MIN = 4,
  parameter int CNT_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pre_n,
  input  logic             sync_n,
  output logic [CNT_W-1:0] cnt_o,
  output logic             rel_o,
  output logic             done_o,
  output logic             short_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             reach;

  // Count edges seen with the synchronised reset low; clear once released.
  always_comb begin
    if (sync_n) cnt_nxt = '0;
    else        cnt_nxt = CNT_W'(dcrs_pkg::sat_inc(32'(cnt_q), EDGE_MIN));
  end

  assign reach = (cnt_nxt == CNT_W'(EDGE_MIN));
  assign rel_o = pre_n & ~sync_n;   // synchronised reset releases at this edge

  always_ff @(posedge clk) begin
    cnt_q <= cnt_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o  <= 1'b0;
      short_o <= 1'b0;
    end else if (rel_o) begin
      done_o  <= reach;
      short_o <= ~reach;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/dcrs_ofs_latch.sv
module dcrs_ofs_latch #(
  parameter int OFS_W = 2
) (
  input  logic             rst_n,
  input  logic [OFS_W-1:0] sel,
  output logic [OFS_W-1:0] code
);
  // Captured once per reset release; held otherwise.
  always_ff @(posedge rst_n) begin
    code <= sel;
  end
endmodule

// File: rtl/dual_clk_rst_seq.sv
module dual_clk_rst_seq #(
  parameter int EDGE_MIN    = 4,
  parameter int SYNC_STAGES = 2,
  parameter int OFS_W       = 2
) (
  input  logic                           clk_a,
  input  logic                           clk_b,
  input  logic                           rst_n,
  input  logic [OFS_W-1:0]               ofs_sel,
  input  logic [dcrs_pkg::NUM_FLAGS-1:0] live_flags,
  output logic                           done_a,
  output logic                           done_b,
  output logic                           rst_err,
  output logic [dcrs_pkg::NUM_FLAGS-1:0] flags_o,
  output logic [OFS_W-1:0]               ofs_code
);
  localparam int CNT_W   = $clog2(EDGE_MIN + 1);
  localparam int NUM_DOM = dcrs_pkg::NUM_DOM;

  logic [NUM_DOM-1:0] clk_v;
  logic [NUM_DOM-1:0] pre_v, sync_v, rel_v, done_v, short_v;
  logic [CNT_W-1:0]   cnt_v [NUM_DOM];

  assign clk_v = {clk_b, clk_a};

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    dcrs_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk_v[d]),
      .rst_n  (rst_n),
      .pre_n  (pre_v[d]),
      .sync_n (sync_v[d])
    );
    dcrs_edge_qual #(.EDGE_MIN(EDGE_MIN), .CNT_W(CNT_W)) u_qual (
      .clk     (clk_v[d]),
      .rst_n   (rst_n),
      .pre_n   (pre_v[d]),
      .sync_n  (sync_v[d]),
      .cnt_o   (cnt_v[d]),
      .rel_o   (rel_v[d]),
      .done_o  (done_v[d]),
      .short_o (short_v[d])
    );
  end

  dcrs_ofs_latch #(.OFS_W(OFS_W)) u_ofs (
    .rst_n (rst_n),
    .sel   (ofs_sel),
    .code  (ofs_code)
  );

  // Named internal events for the checker.
  logic             s1_a, s2_a, s1_b, s2_b, rel_a, rel_b, err_a, err_b, both_rdy;
  logic [CNT_W-1:0] cnt_a, cnt_b;
  assign s1_a  = pre_v[0];
  assign s2_a  = sync_v[0];
  assign s1_b  = pre_v[1];
  assign s2_b  = sync_v[1];
  assign rel_a = rel_v[0];
  assign rel_b = rel_v[1];
  assign err_a = short_v[0];
  assign err_b = short_v[1];
  assign cnt_a = cnt_v[0];
  assign cnt_b = cnt_v[1];

  assign both_rdy = rst_n & (&done_v);
  assign done_a   = done_v[0];
  assign done_b   = done_v[1];
  assign rst_err  = |short_v;
  assign flags_o  = both_rdy ? live_flags : dcrs_pkg::init_flags();
endmodule

// File: rtl/dcrs_checker.sv
module dcrs_checker #(
  parameter int EDGE_MIN = 4,
  parameter int CNT_W    = 3,
  parameter int OFS_W    = 2
) (
  input logic                           clk_a,
  input logic                           clk_b,
  input logic                           rst_n,
  input logic                           s1_a,
  input logic                           s2_a,
  input logic                           s1_b,
  input logic                           s2_b,
  input logic                           rel_a,
  input logic                           rel_b,
  input logic [CNT_W-1:0]               cnt_a,
  input logic [CNT_W-1:0]               cnt_b,
  input logic                           done_a,
  input logic                           done_b,
  input logic                           err_a,
  input logic                           err_b,
  input logic                           rst_err,
  input logic [dcrs_pkg::NUM_FLAGS-1:0] flags_o,
  input logic [OFS_W-1:0]               ofs_code
);
  p_sync_order_a_r1: assert property (@(posedge clk_a) disable iff (!rst_n)
    $rose(s2_a) |-> $past(s1_a));
  p_sync_order_b_r1: assert property (@(posedge clk_b) disable iff (!rst_n)
    $rose(s2_b) |-> $past(s1_b));

  p_cnt_sat_a_r2: assert property (@(posedge clk_a) disable iff (!rst_n)
    cnt_a <= CNT_W'(EDGE_MIN));
  p_cnt_sat_b_r2: assert property (@(posedge clk_b) disable iff (!rst_n)
    cnt_b <= CNT_W'(EDGE_MIN));
  p_cnt_clear_a_r2: assert property (@(posedge clk_a) disable iff (!rst_n)
    s2_a |=> (cnt_a == '0));

  p_done_rise_a_r3: assert property (@(posedge clk_a) disable iff (!rst_n)
    $rose(done_a) |-> $past(rel_a));
  p_done_hold_a_r3: assert property (@(posedge clk_a) disable iff (!rst_n)
    !rel_a |=> $stable(done_a));
  p_done_hold_b_r3: assert property (@(posedge clk_b) disable iff (!rst_n)
    !rel_b |=> $stable(done_b));

  p_done_excl_a_r4: assert property (@(posedge clk_a) disable iff (!rst_n)
    !(done_a && err_a));
  p_done_excl_b_r4: assert property (@(posedge clk_b) disable iff (!rst_n)
    !(done_b && err_b));
  p_err_rise_a_r4: assert property (@(posedge clk_a) disable iff (!rst_n)
    $rose(err_a) |-> $past(rel_a));

  p_err_flags_r5: assert property (@(posedge clk_a) disable iff (!rst_n)
    rst_err |-> (flags_o == dcrs_pkg::init_flags()));

  p_ofs_hold_r7: assert property (@(posedge clk_a) disable iff (!rst_n)
    $past(rst_n) |-> $stable(ofs_code));
endmodule

bind dual_clk_rst_seq dcrs_checker #(
  .EDGE_MIN (EDGE_MIN),
  .CNT_W    (CNT_W),
  .OFS_W    (OFS_W)
) u_chk (
  .clk_a    (clk_a),
  .clk_b    (clk_b),
  .rst_n    (rst_n),
  .s1_a     (s1_a),
  .s2_a     (s2_a),
  .s1_b     (s1_b),
  .s2_b     (s2_b),
  .rel_a    (rel_a),
  .rel_b    (rel_b),
  .cnt_a    (cnt_a),
  .cnt_b    (cnt_b),
  .done_a   (done_a),
  .done_b   (done_b),
  .err_a    (err_a),
  .err_b    (err_b),
  .rst_err  (rst_err),
  .flags_o  (flags_o),
  .ofs_code (ofs_code)
);

// File: tb/tb_dual_clk_rst_seq.sv
module tb_dual_clk_rst_seq;
  localparam int CLK_PERIOD = 10;
  localparam int EDGE_MIN   = 4;
  localparam int SYNC_LAT   = 2;
  localparam logic [5:0] START_PAT = 6'b111000;

  logic       clk_a = 1'b0, clk_b = 1'b0, rst_n = 1'b1;
  logic [1:0] ofs_sel = 2'b00;
  logic [5:0] live_flags = 6'b010101;
  logic       done_a, done_b, rst_err;
  logic [5:0] flags_o;
  logic [1:0] ofs_code;

  dual_clk_rst_seq dut (
    .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n), .ofs_sel(ofs_sel),
    .live_flags(live_flags), .done_a(done_a), .done_b(done_b),
    .rst_err(rst_err), .flags_o(flags_o), .ofs_code(ofs_code)
  );

  typedef struct {
    string      tag;
    logic       da, db, er;
    logic [5:0] fl;
    string      fl_req;
    logic [1:0] of;
    bit         chk_of;
  } exp_t;

  exp_t exp_q[$];
  event item_ev;
  int   n_chk = 0, n_err = 0;
  bit   ended = 0;
  logic [1:0] last_ofs;

  task automatic check(string req, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s (%s) actual=%0h expected=%0h", req, tag, act, exp);
    end
  endtask

  // Monitor: pops expected items and compares against the outputs.
  initial begin
    forever begin
      @(item_ev);
      while (exp_q.size() > 0) begin
        exp_t it;
        it = exp_q.pop_front();
        check("R3", {it.tag, " done_a"}, 32'(done_a), 32'(it.da));
        check("R3", {it.tag, " done_b"}, 32'(done_b), 32'(it.db));
        check("R4", {it.tag, " rst_err"}, 32'(rst_err), 32'(it.er));
        check(it.fl_req, {it.tag, " flags"}, 32'(flags_o), 32'(it.fl));
        if (it.chk_of) check("R7", {it.tag, " ofs_code"}, 32'(ofs_code), 32'(it.of));
      end
    end
  end

  task automatic push(string tag, logic da, logic db, logic er, logic [5:0] fl,
                      string fl_req, logic [1:0] of, bit chk_of);
    exp_t it;
    it.tag = tag; it.da = da; it.db = db; it.er = er;
    it.fl = fl; it.fl_req = fl_req; it.of = of; it.chk_of = chk_of;
    exp_q.push_back(it);
    -> item_ev;
    #1;
  endtask

  task automatic pulse_a(int n);
    for (int i = 0; i < n; i++) begin
      #(CLK_PERIOD/2) clk_a = 1'b1;
      #(CLK_PERIOD/2) clk_a = 1'b0;
    end
  endtask

  task automatic pulse_b(int n);
    for (int i = 0; i < n; i++) begin
      #(CLK_PERIOD/2) clk_b = 1'b1;
      #(CLK_PERIOD/2) clk_b = 1'b0;
    end
  endtask

  // Driver: one reset episode with na/nb edges while rst_n is low.
  task automatic episode(string tag, int na, int nb, logic [1:0] sel,
                         logic [1:0] sel_after, bit chk_prev_ofs);
    logic ok_a, ok_b;
    ok_a = (na + SYNC_LAT >= EDGE_MIN);
    ok_b = (nb + SYNC_LAT >= EDGE_MIN);
    ofs_sel = sel;
    #2 rst_n = 1'b0;
    #1;
    // R3 R4 R5: asynchronous clear on reset entry
    push({tag, " entry"}, 0, 0, 0, START_PAT, "R5", last_ofs, chk_prev_ofs);
    pulse_a(na);
    pulse_b(nb);
    push({tag, " in-reset"}, 0, 0, 0, START_PAT, "R5", last_ofs, chk_prev_ofs);
    #2 rst_n = 1'b1;
    #1 ofs_sel = sel_after;          // R7: later change must not be captured
    pulse_a(1);
    // R1: one edge is not enough to release the synchroniser
    push({tag, " A+1 R1"}, 0, 0, 0, START_PAT, "R5", sel, 1);
    pulse_a(1);
    // R8: domain A resolves alone while B is still held
    push({tag, " A+2 R8"}, ok_a, 0, !ok_a, START_PAT, "R5", sel, 1);
    pulse_b(1);
    push({tag, " B+1 R1"}, ok_a, 0, !ok_a, START_PAT, "R5", sel, 1);
    pulse_b(1);
    push({tag, " B+2"}, ok_a, ok_b, !(ok_a && ok_b),
         (ok_a && ok_b) ? live_flags : START_PAT,
         (ok_a && ok_b) ? "R6" : "R5", sel, 1);
    pulse_a(2);
    pulse_b(2);
    push({tag, " settled R3"}, ok_a, ok_b, !(ok_a && ok_b),
         (ok_a && ok_b) ? live_flags : START_PAT,
         (ok_a && ok_b) ? "R6" : "R5", sel, 1);
    last_ofs = sel;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!ended) begin
      ended = 1;
      n_err++;
      n_chk++;
      $display("FAIL watchdog all-R actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    last_ofs = 2'b00;
    // Power-up: reset high so both counters clear (R2)
    pulse_a(3);
    pulse_b(3);
    episode("full4",   4,  4, 2'b10, 2'b01, 0);
    // R6: live flags pass through after qualification
    live_flags = 6'b100110;
    #1;
    push("live change R6", 1, 1, 0, 6'b100110, "R6", 2'b10, 1);
    episode("shortA",  1,  5, 2'b01, 2'b11, 1);   // R4 R8
    episode("edge2",   2,  2, 2'b11, 2'b00, 1);   // R2 boundary: 2+2 = 4
    episode("both1",   1,  1, 2'b00, 2'b10, 1);   // R4
    episode("sat20",  20,  0, 2'b10, 2'b01, 1);   // R2 saturation, B short
    episode("ok63",    6,  3, 2'b01, 2'b10, 1);   // R2 R3
    live_flags = 6'b000011;
    #1;
    push("live change2 R6", 1, 1, 0, 6'b000011, "R6", 2'b01, 1);
    #5;
    if (!ended) begin
      ended = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule